// File: doc/BRIEF.md
# VBI Line Qualifier and Horizontal Doubler

This block counts video lines from each vertical sync and decides, for the field in progress, whether the current line carries vertical blanking interval (VBI) data. Each field (odd or even) has its own line offset, which is the number of line periods from the sync edge to video line 2. Each field also has its own sparse enable mask over lines 2 to 24. The field flag input picks which offset and mask apply. Setting the top mask bit turns every active-video line, from line 24 onward, into a VBI line.

Pixels arrive from one of two sources, chosen by a control bit. A pixel is forwarded on the VBI stream only when the current line is qualified. Forwarded pixels either pass through after one register stage, or each one is emitted twice in a row when horizontal doubling is enabled. While doubling, the block lowers its ready output for the repeat cycle so that the source holds its next pixel.

Configuration is written through a small address/data port into staging registers. All of it is copied into the working set at the next rising edge of vsync, so a field never sees a change part way through.

Top module: `vbi_line_qual`

## Requirements
- R1: After reset, vbi_line_o=0, vbi_valid_o=0, pix_ready_o=1 and line_no_o=2. All configuration is zero: both masks clear, both offsets 0, source 0, doubling off.
- R2: The line counter clears on a rising edge of vsync_i and increments on each line_start_i strobe. line_no_o equals counter − offset + 2 when counter ≥ offset, and 0 otherwise. Outputs reflect the new count in the cycle after the clock edge.
- R3: field_odd_i=1 selects the odd-field offset and mask. field_odd_i=0 selects the even-field offset and mask.
- R4: Mask bit n, for n from 2 to 24, flags video line n as a VBI line (vbi_line_o=1). A clear bit leaves line n unflagged.
- R5: When bit 24 of the selected mask is set, every line numbered 24 or higher is flagged.
- R6: A line with line_no_o=0 (before line 2) is never flagged. With both masks all zero, vbi_line_o never asserts.
- R7: Configuration writes take effect only at the next rising edge of vsync_i. Before that edge, outputs behave as they did under the old configuration.
- R8: Control bit 0 selects the pixel source: 0 selects src0, 1 selects src1. Control bit 1 enables doubling.
- R9: With doubling off, a valid pixel from the selected source on a flagged line appears on vbi_valid_o/vbi_data_o one cycle later. Pixels on unflagged lines produce no output.
- R10: With doubling on, an accepted pixel is output on two consecutive cycles with the same data. pix_ready_o is 0 in the cycle after acceptance, and input offered in that cycle is ignored.
- R11: Register map: address 0 is control, 1 is the odd mask (wdata bit n is line n), 2 is the odd offset, 3 is the even mask, and 4 is the even offset (low OFS_W bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register address |
| cfg_wdata_i | input | CFG_W | Configuration write data |
| vsync_i | input | 1 | Vertical sync level |
| line_start_i | input | 1 | One-cycle strobe at each line start |
| field_odd_i | input | 1 | 1 = odd field, 0 = even field |
| src0_valid_i | input | 1 | Source 0 pixel valid |
| src0_data_i | input | DATA_W | Source 0 pixel |
| src1_valid_i | input | 1 | Source 1 pixel valid |
| src1_data_i | input | DATA_W | Source 1 pixel |
| pix_ready_o | output | 1 | Block can take a pixel this cycle |
| vbi_line_o | output | 1 | Current line is a VBI line |
| line_no_o | output | LCNT_W+1 | Current video line number, 0 before line 2 |
| vbi_valid_o | output | 1 | VBI output pixel valid |
| vbi_data_o | output | DATA_W | VBI output pixel |

## Verification
The bench walks both fields across the edges of their offsets. A design that off-by-ones the offset arithmetic would flag the line before or after the enabled one. A design that ignores the field flag would report the same result for the same count in both fields. Lines at and beyond 24 are probed in a field with the top bit set and in a field with it clear; a design that treats bit 24 as applying to only one line would miss line 36. Writes are checked before and after the following vsync, which catches a design that applies them immediately. In doubling mode the bench offers a second pixel during the repeat cycle. A design that does not stall would replace the repeated data or drop the repeat.

// File: rtl/vbi_pkg.sv
`timescale 1ns/1ps
package vbi_pkg;
  localparam int unsigned FIRST_LINE = 2;
  localparam int unsigned TOP_LINE   = 24;

  typedef logic [TOP_LINE:FIRST_LINE] line_mask_t;

  typedef enum logic [2:0] {
    CFG_CTRL      = 3'd0,
    CFG_ODD_MASK  = 3'd1,
    CFG_ODD_OFS   = 3'd2,
    CFG_EVEN_MASK = 3'd3,
    CFG_EVEN_OFS  = 3'd4
  } cfg_addr_e;

  typedef struct packed {
    logic upscale;
    logic src_sel;
  } ctrl_t;
endpackage

// File: rtl/vbi_cfg_shadow.sv
`timescale 1ns/1ps
module vbi_cfg_shadow
  import vbi_pkg::*;
#(
  parameter int unsigned CFG_W = 32,
  parameter int unsigned OFS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             vs_rise_i,
  output line_mask_t       odd_mask_o,
  output line_mask_t       even_mask_o,
  output logic [OFS_W-1:0] odd_ofs_o,
  output logic [OFS_W-1:0] even_ofs_o,
  output ctrl_t            ctrl_o
);
  line_mask_t       st_odd_mask, st_even_mask;
  logic [OFS_W-1:0] st_odd_ofs, st_even_ofs;
  ctrl_t            st_ctrl;

  // staging registers, written at any time
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_odd_mask  <= '0;
      st_even_mask <= '0;
      st_odd_ofs   <= '0;
      st_even_ofs  <= '0;
      st_ctrl      <= '0;
    end else if (we_i) begin
      case (cfg_addr_e'(addr_i))
        CFG_CTRL:      st_ctrl      <= '{upscale: wdata_i[1], src_sel: wdata_i[0]};
        CFG_ODD_MASK:  st_odd_mask  <= wdata_i[TOP_LINE:FIRST_LINE];
        CFG_ODD_OFS:   st_odd_ofs   <= wdata_i[OFS_W-1:0];
        CFG_EVEN_MASK: st_even_mask <= wdata_i[TOP_LINE:FIRST_LINE];
        CFG_EVEN_OFS:  st_even_ofs  <= wdata_i[OFS_W-1:0];
        default: ;
      endcase
    end
  end

  // working set, loaded only at field boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odd_mask_o  <= '0;
      even_mask_o <= '0;
      odd_ofs_o   <= '0;
      even_ofs_o  <= '0;
      ctrl_o      <= '0;
    end else if (vs_rise_i) begin
      odd_mask_o  <= st_odd_mask;
      even_mask_o <= st_even_mask;
      odd_ofs_o   <= st_odd_ofs;
      even_ofs_o  <= st_even_ofs;
      ctrl_o      <= st_ctrl;
    end
  end

  // R7
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vs_rise_i |=> $stable(odd_mask_o) && $stable(even_mask_o) &&
                   $stable(odd_ofs_o) && $stable(even_ofs_o) && $stable(ctrl_o));
endmodule

// File: rtl/vbi_line_tracker.sv
`timescale 1ns/1ps
module vbi_line_tracker
  import vbi_pkg::*;
#(
  parameter int unsigned OFS_W  = 8,
  parameter int unsigned LCNT_W = 10,
  localparam int unsigned LN_W  = LCNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vs_rise_i,
  input  logic             line_start_i,
  input  logic             field_odd_i,
  input  line_mask_t       odd_mask_i,
  input  line_mask_t       even_mask_i,
  input  logic [OFS_W-1:0] odd_ofs_i,
  input  logic [OFS_W-1:0] even_ofs_i,
  output logic [LN_W-1:0]  line_no_o,
  output logic             vbi_line_o
);
  logic [LCNT_W-1:0] cnt_q;
  line_mask_t        sel_mask;
  logic [LN_W-1:0]   cnt_x, ofs_x;
  logic              pre_zone, hit, any_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (vs_rise_i)                   cnt_q <= '0;
    else if (line_start_i && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    sel_mask  = field_odd_i ? odd_mask_i : even_mask_i;
    cnt_x     = {1'b0, cnt_q};
    ofs_x     = LN_W'(field_odd_i ? odd_ofs_i : even_ofs_i);
    pre_zone  = cnt_x < ofs_x;
    line_no_o = pre_zone ? '0 : cnt_x - ofs_x + LN_W'(FIRST_LINE);
    hit       = 1'b0;
    for (int l = FIRST_LINE; l <= TOP_LINE; l++)
      if (line_no_o == LN_W'(l)) hit = sel_mask[l];
    if (line_no_o > LN_W'(TOP_LINE)) hit = sel_mask[TOP_LINE];
    any_en     = (|odd_mask_i) | (|even_mask_i);
    vbi_line_o = any_en & ~pre_zone & hit;
  end

  // R2
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_rise_i |=> cnt_q == '0);
  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vs_rise_i && line_start_i && cnt_q != '1) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R6
  pre_zone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_no_o == '0) |-> !vbi_line_o);
  // R6
  no_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (odd_mask_i == '0 && even_mask_i == '0) |-> !vbi_line_o);
endmodule

// File: rtl/vbi_upscaler.sv
`timescale 1ns/1ps
module vbi_upscaler
  import vbi_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned N_SRC  = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  ctrl_t                         ctrl_i,
  input  logic                          vbi_line_i,
  input  logic [N_SRC-1:0]              src_valid_i,
  input  logic [N_SRC-1:0][DATA_W-1:0]  src_data_i,
  output logic                          ready_o,
  output logic                          valid_o,
  output logic [DATA_W-1:0]             data_o
);
  logic              dup_q, sel_valid, acc;
  logic [DATA_W-1:0] sel_data;

  assign sel_valid = src_valid_i[ctrl_i.src_sel];
  assign sel_data  = src_data_i[ctrl_i.src_sel];
  assign ready_o   = ~dup_q;
  assign acc       = sel_valid & vbi_line_i & ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dup_q   <= 1'b0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (dup_q) begin
      dup_q   <= 1'b0;   // repeat cycle, data held
      valid_o <= 1'b1;
    end else begin
      valid_o <= acc;
      dup_q   <= acc & ctrl_i.upscale;
      if (acc) data_o <= sel_data;
    end
  end

  // R9
  pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !ctrl_i.upscale) |=> valid_o && data_o == $past(sel_data));
  // R9
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc && ready_o) |=> !valid_o);
  // R10
  dup_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && ctrl_i.upscale) |=> valid_o && !ready_o);
  // R10
  dup_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_o) |=> valid_o && ready_o && $stable(data_o));
endmodule

// File: rtl/vbi_line_qual.sv
`timescale 1ns/1ps
module vbi_line_qual
  import vbi_pkg::*;
#(
  parameter int unsigned CFG_W  = 32,
  parameter int unsigned OFS_W  = 8,
  parameter int unsigned LCNT_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_addr_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              vsync_i,
  input  logic              line_start_i,
  input  logic              field_odd_i,
  input  logic              src0_valid_i,
  input  logic [DATA_W-1:0] src0_data_i,
  input  logic              src1_valid_i,
  input  logic [DATA_W-1:0] src1_data_i,
  output logic              pix_ready_o,
  output logic              vbi_line_o,
  output logic [LCNT_W:0]   line_no_o,
  output logic              vbi_valid_o,
  output logic [DATA_W-1:0] vbi_data_o
);
  logic             vs_q, vs_rise;
  line_mask_t       odd_mask, even_mask;
  logic [OFS_W-1:0] odd_ofs, even_ofs;
  ctrl_t            ctrl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vs_q <= 1'b0;
    else         vs_q <= vsync_i;
  end
  assign vs_rise = vsync_i & ~vs_q;

  vbi_cfg_shadow #(.CFG_W(CFG_W), .OFS_W(OFS_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .vs_rise_i(vs_rise),
    .odd_mask_o(odd_mask), .even_mask_o(even_mask),
    .odd_ofs_o(odd_ofs), .even_ofs_o(even_ofs), .ctrl_o(ctrl)
  );

  vbi_line_tracker #(.OFS_W(OFS_W), .LCNT_W(LCNT_W)) u_trk (
    .clk_i, .rst_ni,
    .vs_rise_i(vs_rise), .line_start_i, .field_odd_i,
    .odd_mask_i(odd_mask), .even_mask_i(even_mask),
    .odd_ofs_i(odd_ofs), .even_ofs_i(even_ofs),
    .line_no_o, .vbi_line_o
  );

  vbi_upscaler #(.DATA_W(DATA_W), .N_SRC(2)) u_ups (
    .clk_i, .rst_ni,
    .ctrl_i(ctrl), .vbi_line_i(vbi_line_o),
    .src_valid_i({src1_valid_i, src0_valid_i}),
    .src_data_i({src1_data_i, src0_data_i}),
    .ready_o(pix_ready_o), .valid_o(vbi_valid_o), .data_o(vbi_data_o)
  );
endmodule

// File: tb/vbi_line_qual_bench.sv
`timescale 1ns/1ps
module vbi_line_qual_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        vsync = 1'b0, line_start = 1'b0, field_odd = 1'b1;
  logic        s0_v = 1'b0, s1_v = 1'b0;
  logic [7:0]  s0_d = '0, s1_d = '0;
  logic        ready, vline, vvalid;
  logic [10:0] line_no;
  logic [7:0]  vdata;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int cur_cnt = 0;
  logic cur_field = 1'b1;

  always #2.5 clk = ~clk;

  vbi_line_qual u_vbi_line_qual (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .vsync_i(vsync), .line_start_i(line_start), .field_odd_i(field_odd),
    .src0_valid_i(s0_v), .src0_data_i(s0_d),
    .src1_valid_i(s1_v), .src1_data_i(s1_d),
    .pix_ready_o(ready), .vbi_line_o(vline), .line_no_o(line_no),
    .vbi_valid_o(vvalid), .vbi_data_o(vdata)
  );

  typedef struct packed {
    logic        fld;
    logic [9:0]  cnt;
    logic [10:0] line;
    logic        flag;
  } vec_t;
  localparam int NV = 14;
  // odd: offset 3, lines 2 and 5; even: offset 6, lines 3 and 24 (all active)
  localparam vec_t VEC [NV] = '{
    '{1'b1, 10'd0,  11'd0,  1'b0},
    '{1'b1, 10'd2,  11'd0,  1'b0},
    '{1'b1, 10'd3,  11'd2,  1'b1},
    '{1'b1, 10'd4,  11'd3,  1'b0},
    '{1'b1, 10'd6,  11'd5,  1'b1},
    '{1'b1, 10'd7,  11'd6,  1'b0},
    '{1'b1, 10'd25, 11'd24, 1'b0},
    '{1'b0, 10'd5,  11'd0,  1'b0},
    '{1'b0, 10'd6,  11'd2,  1'b0},
    '{1'b0, 10'd7,  11'd3,  1'b1},
    '{1'b0, 10'd8,  11'd4,  1'b0},
    '{1'b0, 10'd27, 11'd23, 1'b0},
    '{1'b0, 10'd28, 11'd24, 1'b1},
    '{1'b0, 10'd40, 11'd36, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic vs_pulse();
    vsync = 1'b1; tick(); vsync = 1'b0; cur_cnt = 0;
  endtask

  task automatic go(input logic f, input int c, input bit force_vs);
    if (force_vs || f != cur_field || c < cur_cnt) vs_pulse();
    field_odd = f; cur_field = f;
    while (cur_cnt < c) begin
      line_start = 1'b1; tick(); line_start = 1'b0; cur_cnt++;
    end
    #1;
  endtask

  task automatic pix(input logic v0, input logic [7:0] d0, input logic v1, input logic [7:0] d1);
    s0_v = v0; s0_d = d0; s1_v = v1; s1_d = d1;
    tick();
    s0_v = 1'b0; s1_v = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #12 rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 vbi_line", vline, 0);
    chk("R1 vbi_valid", vvalid, 0);
    chk("R1 ready", ready, 1);
    chk("R1 line_no", line_no, 2);

    // R7 / R11: odd mask bit 2 staged, not yet active
    wr(3'd1, 32'h4);
    #1;
    chk("R7 before vsync flag", vline, 0);
    go(1'b1, 0, 1'b1);
    chk("R7 after vsync flag", vline, 1);
    chk("R2 line_no after clear", line_no, 2);

    // table configuration (R11 map)
    wr(3'd1, 32'h0000_0024);
    wr(3'd2, 32'd3);
    wr(3'd3, 32'h0100_0008);
    wr(3'd4, 32'd6);
    #1;
    chk("R7 offset unchanged before vsync", line_no, 2);

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      go(VEC[i].fld, int'(VEC[i].cnt), i == 0);
      chk($sformatf("R2 line_no row %0d", i), line_no, VEC[i].line);
      chk($sformatf("R4 R5 R6 R3 flag row %0d", i), vline, VEC[i].flag);
    end

    // R9 pass-through from src0 on flagged odd line 2
    go(1'b1, 3, 1'b1);
    chk("R9 ready in pass mode", ready, 1);
    pix(1'b1, 8'h5A, 1'b1, 8'hC3);
    chk("R9 valid", vvalid, 1);
    chk("R8 src0 data", vdata, 8'h5A);
    tick();
    chk("R9 single output", vvalid, 0);
    go(1'b1, 4, 1'b0);
    pix(1'b1, 8'h77, 1'b0, 8'h00);
    chk("R9 unflagged line ignored", vvalid, 0);

    // R8 select src1
    wr(3'd0, 32'h1);
    go(1'b1, 3, 1'b1);
    pix(1'b1, 8'h5A, 1'b1, 8'hC3);
    chk("R8 src1 valid", vvalid, 1);
    chk("R8 src1 data", vdata, 8'hC3);
    pix(1'b1, 8'h66, 1'b0, 8'h00);
    chk("R8 src0 ignored", vvalid, 0);

    // R10 doubling on src1
    wr(3'd0, 32'h3);
    go(1'b1, 3, 1'b1);
    chk("R10 ready before", ready, 1);
    s1_v = 1'b1; s1_d = 8'h11;
    tick();
    s1_d = 8'h22;          // offered during repeat cycle
    chk("R10 first valid", vvalid, 1);
    chk("R10 first data", vdata, 8'h11);
    chk("R10 ready low", ready, 0);
    tick();
    s1_v = 1'b0;
    chk("R10 repeat valid", vvalid, 1);
    chk("R10 repeat data", vdata, 8'h11);
    chk("R10 ready back", ready, 1);
    tick();
    chk("R10 stall input dropped", vvalid, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule